// File: doc/BRIEF.md
# Shared Video and Palette Memory Arbiter

This block lets several requesters in a graphics controller share two single-port memories. The first is a frame memory with three requesters: a software register port, a drawing-engine port and a display-refresh port. The second is a colour palette memory with two requesters: the software port and the refresh port. Each requester presents an address, write data (the refresh ports only read, so they have no write data), an active-low write strobe and an active-low chip enable. The arbiter forwards one granted request per memory per cycle to the memory side.

The software port always wins on both memories. On the frame memory, the drawing engine and the refresh port alternate fairly with a one-bit round-robin pointer. On the palette memory, the refresh port is served only when software is idle. No requester is stalled by a handshake. A port that loses keeps its chip enable low and tries again in the next cycle. Each lower-priority port gets a flag in its grant cycle that says its read data will be valid on the following cycle, because the memories have a one-cycle read latency. The memory read bus is returned unchanged to every requester of that memory.

Top module: `shared_vmem_arbiter`

## Requirements
- R1: When `vsw_cen_n` is low, the frame memory gets the software address, write data and write strobe in the same cycle, with `vmem_cen_n` low. Neither lower port's ready flag is raised in that cycle.
- R2: When software is idle on the frame memory and both the engine and refresh chip enables are low, the port the pointer favours is granted. After reset the pointer favours the refresh port.
- R3: The round-robin pointer changes only on a clock edge in which the engine or refresh port was granted, and it then favours the other of the two. Cycles with a software grant or with no request leave it unchanged.
- R4: When software is idle and only one of the engine and refresh ports requests, that port is granted whatever the pointer says.
- R5: `veng_rd_next` / `vref_rd_next` is high only in a cycle where that port is granted a read (write strobe high). An engine write raises no flag. At most one flag is high per cycle.
- R6: A granted refresh access drives the memory write strobe high and the memory write data to zero, on both memories.
- R7: On the palette memory, software wins whenever `lsw_cen_n` is low. The refresh port is granted, with `lref_rd_next` high, only when software is idle.
- R8: With no chip enable low, including during reset, the memory-side chip enable and write strobe of that memory are both high.
- R9: `vmem_rdata` appears unchanged on all three frame-memory read outputs. `lmem_rdata` appears unchanged on both palette read outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsw_addr | input | VADDR_W | Software frame address |
| vsw_wdata | input | DW | Software frame write data |
| vsw_wen_n | input | 1 | Software frame write strobe, active low |
| vsw_cen_n | input | 1 | Software frame chip enable, active low |
| vsw_rdata | output | DW | Software frame read data |
| veng_addr | input | VADDR_W | Engine frame address |
| veng_wdata | input | DW | Engine frame write data |
| veng_wen_n | input | 1 | Engine write strobe, active low |
| veng_cen_n | input | 1 | Engine chip enable, active low |
| veng_rdata | output | DW | Engine read data |
| veng_rd_next | output | 1 | Engine read data valid next cycle |
| vref_addr | input | VADDR_W | Refresh frame address |
| vref_cen_n | input | 1 | Refresh frame chip enable, active low |
| vref_rdata | output | DW | Refresh frame read data |
| vref_rd_next | output | 1 | Refresh frame read data valid next cycle |
| vmem_addr | output | VADDR_W | Frame memory address |
| vmem_wdata | output | DW | Frame memory write data |
| vmem_wen_n | output | 1 | Frame memory write strobe, active low |
| vmem_cen_n | output | 1 | Frame memory chip enable, active low |
| vmem_rdata | input | DW | Frame memory read data |
| lsw_addr | input | LADDR_W | Software palette address |
| lsw_wdata | input | DW | Software palette write data |
| lsw_wen_n | input | 1 | Software palette write strobe, active low |
| lsw_cen_n | input | 1 | Software palette chip enable, active low |
| lsw_rdata | output | DW | Software palette read data |
| lref_addr | input | LADDR_W | Refresh palette address |
| lref_cen_n | input | 1 | Refresh palette chip enable, active low |
| lref_rdata | output | DW | Refresh palette read data |
| lref_rd_next | output | 1 | Refresh palette read data valid next cycle |
| lmem_addr | output | LADDR_W | Palette memory address |
| lmem_wdata | output | DW | Palette memory write data |
| lmem_wen_n | output | 1 | Palette memory write strobe, active low |
| lmem_cen_n | output | 1 | Palette memory chip enable, active low |
| lmem_rdata | input | DW | Palette memory read data |

## Verification
The bench runs a reference model of the pointer alongside every frame-memory cycle. It checks the first contended cycle after reset, which a pointer with the wrong reset value would hand to the engine. It places software cycles and idle cycles between contended ones, where a pointer that toggles on every edge or on software grants would pick the wrong winner. It issues a single requester while the pointer favours the other port, where a strict alternator would leave the memory idle. It also issues an engine write, where a flag decoded from the grant alone would wrongly report read data.

// File: rtl/vmem_arb_pkg.sv
package vmem_arb_pkg;

    localparam int WORD_W = 16;

    // Which lower-priority frame requester wins the next tie
    typedef enum logic {
        FAV_ENGINE  = 1'b0,
        FAV_REFRESH = 1'b1
    } rr_fav_e;

    // One-hot0 grant for the frame memory
    typedef struct packed {
        logic refr;
        logic eng;
        logic sw;
    } vgrant_t;

    function automatic vgrant_t vpick(logic sw_req, logic eng_req,
                                      logic refr_req, rr_fav_e fav);
        vgrant_t g;
        g = '0;
        if (sw_req) begin
            g.sw = 1'b1;
        end else if (eng_req && refr_req) begin
            if (fav == FAV_REFRESH) g.refr = 1'b1;
            else                    g.eng  = 1'b1;
        end else begin
            g.eng  = eng_req;
            g.refr = refr_req;
        end
        return g;
    endfunction

    function automatic rr_fav_e fav_after(vgrant_t g, rr_fav_e cur);
        if (g.eng)       return FAV_REFRESH;
        else if (g.refr) return FAV_ENGINE;
        else             return cur;
    endfunction

endpackage

// File: rtl/arb_rr_grant.sv
module arb_rr_grant
    import vmem_arb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sw_req,
    input  logic    eng_req,
    input  logic    refr_req,
    output vgrant_t gnt
);

    rr_fav_e fav_q;

    always_comb begin
        gnt = vpick(sw_req, eng_req, refr_req, fav_q);
    end

    always_ff @(posedge clk) begin
        if (rst) fav_q <= FAV_REFRESH;
        else     fav_q <= fav_after(gnt, fav_q);
    end

endmodule

// File: rtl/arb_fixed_grant.sv
module arb_fixed_grant #(
    parameter int N = 2
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    // Index 0 has the highest priority
    logic [N:0] taken;

    assign taken[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_prio
        assign gnt[i]     = req[i] & ~taken[i];
        assign taken[i+1] = taken[i] | req[i];
    end

endmodule

// File: rtl/arb_req_mux.sv
module arb_req_mux #(
    parameter int N  = 3,
    parameter int AW = 14,
    parameter int DW = 16
) (
    input  logic [N-1:0]    gnt,
    input  logic [N*AW-1:0] addr_all,
    input  logic [N*DW-1:0] wdata_all,
    input  logic [N-1:0]    wen_n_all,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            mem_wen_n,
    output logic            mem_cen_n
);

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_wen_n = 1'b1;
        mem_cen_n = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) begin
                mem_addr  = addr_all[i*AW +: AW];
                mem_wdata = wdata_all[i*DW +: DW];
                mem_wen_n = wen_n_all[i];
                mem_cen_n = 1'b0;
            end
        end
    end

endmodule

// File: rtl/shared_vmem_arbiter.sv
module shared_vmem_arbiter
    import vmem_arb_pkg::*;
#(
    parameter int VADDR_W = 14,
    parameter int LADDR_W = 8,
    parameter int DW      = WORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [VADDR_W-1:0] vsw_addr,
    input  logic [DW-1:0]      vsw_wdata,
    input  logic               vsw_wen_n,
    input  logic               vsw_cen_n,
    output logic [DW-1:0]      vsw_rdata,
    input  logic [VADDR_W-1:0] veng_addr,
    input  logic [DW-1:0]      veng_wdata,
    input  logic               veng_wen_n,
    input  logic               veng_cen_n,
    output logic [DW-1:0]      veng_rdata,
    output logic               veng_rd_next,
    input  logic [VADDR_W-1:0] vref_addr,
    input  logic               vref_cen_n,
    output logic [DW-1:0]      vref_rdata,
    output logic               vref_rd_next,
    output logic [VADDR_W-1:0] vmem_addr,
    output logic [DW-1:0]      vmem_wdata,
    output logic               vmem_wen_n,
    output logic               vmem_cen_n,
    input  logic [DW-1:0]      vmem_rdata,
    input  logic [LADDR_W-1:0] lsw_addr,
    input  logic [DW-1:0]      lsw_wdata,
    input  logic               lsw_wen_n,
    input  logic               lsw_cen_n,
    output logic [DW-1:0]      lsw_rdata,
    input  logic [LADDR_W-1:0] lref_addr,
    input  logic               lref_cen_n,
    output logic [DW-1:0]      lref_rdata,
    output logic               lref_rd_next,
    output logic [LADDR_W-1:0] lmem_addr,
    output logic [DW-1:0]      lmem_wdata,
    output logic               lmem_wen_n,
    output logic               lmem_cen_n,
    input  logic [DW-1:0]      lmem_rdata
);

    localparam int VN = 3;  // frame requesters: sw, engine, refresh
    localparam int LN = 2;  // palette requesters: sw, refresh

    // ---------------- frame memory ----------------
    vgrant_t v_gnt;

    arb_rr_grant u_vgrant (
        .clk      (clk),
        .rst      (rst),
        .sw_req   (~vsw_cen_n),
        .eng_req  (~veng_cen_n),
        .refr_req (~vref_cen_n),
        .gnt      (v_gnt)
    );

    logic [VN-1:0]         v_gnt_vec;
    logic [VN*VADDR_W-1:0] v_addr_all;
    logic [VN*DW-1:0]      v_wdata_all;
    logic [VN-1:0]         v_wen_all;

    assign v_gnt_vec   = {v_gnt.refr, v_gnt.eng, v_gnt.sw};
    assign v_addr_all  = {vref_addr, veng_addr, vsw_addr};
    assign v_wdata_all = {{DW{1'b0}}, veng_wdata, vsw_wdata};
    assign v_wen_all   = {1'b1, veng_wen_n, vsw_wen_n};

    arb_req_mux #(.N(VN), .AW(VADDR_W), .DW(DW)) u_vmux (
        .gnt       (v_gnt_vec),
        .addr_all  (v_addr_all),
        .wdata_all (v_wdata_all),
        .wen_n_all (v_wen_all),
        .mem_addr  (vmem_addr),
        .mem_wdata (vmem_wdata),
        .mem_wen_n (vmem_wen_n),
        .mem_cen_n (vmem_cen_n)
    );

    assign veng_rd_next = v_gnt.eng & veng_wen_n;
    assign vref_rd_next = v_gnt.refr;

    assign vsw_rdata  = vmem_rdata;
    assign veng_rdata = vmem_rdata;
    assign vref_rdata = vmem_rdata;

    // ---------------- palette memory ----------------
    logic [LN-1:0] l_gnt;

    arb_fixed_grant #(.N(LN)) u_lgrant (
        .req ({~lref_cen_n, ~lsw_cen_n}),
        .gnt (l_gnt)
    );

    arb_req_mux #(.N(LN), .AW(LADDR_W), .DW(DW)) u_lmux (
        .gnt       (l_gnt),
        .addr_all  ({lref_addr, lsw_addr}),
        .wdata_all ({{DW{1'b0}}, lsw_wdata}),
        .wen_n_all ({1'b1, lsw_wen_n}),
        .mem_addr  (lmem_addr),
        .mem_wdata (lmem_wdata),
        .mem_wen_n (lmem_wen_n),
        .mem_cen_n (lmem_cen_n)
    );

    assign lref_rd_next = l_gnt[1];

    assign lsw_rdata  = lmem_rdata;
    assign lref_rdata = lmem_rdata;

endmodule

// File: rtl/vmem_arb_checker.sv
module vmem_arb_checker #(
    parameter int VADDR_W = 14,
    parameter int DW      = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [VADDR_W-1:0] vsw_addr,
    input logic               vsw_cen_n,
    input logic               veng_cen_n,
    input logic               veng_wen_n,
    input logic               veng_rd_next,
    input logic               vref_cen_n,
    input logic               vref_rd_next,
    input logic [VADDR_W-1:0] vmem_addr,
    input logic [DW-1:0]      vmem_wdata,
    input logic               vmem_wen_n,
    input logic               vmem_cen_n,
    input logic               lsw_cen_n,
    input logic               lref_cen_n,
    input logic               lref_rd_next,
    input logic [DW-1:0]      lmem_wdata,
    input logic               lmem_wen_n,
    input logic               lmem_cen_n
);

    logic both_low;
    assign both_low = vsw_cen_n && !veng_cen_n && !vref_cen_n;

    assert_sw_wins_R1: assert property (@(posedge clk) disable iff (rst)
        !vsw_cen_n |-> (!vmem_cen_n && vmem_addr == vsw_addr
                        && !veng_rd_next && !vref_rd_next));

    assert_alt_to_refresh_R3: assert property (@(posedge clk) disable iff (rst)
        (both_low && veng_rd_next) ##1 both_low |-> vref_rd_next);

    assert_alt_to_engine_R3: assert property (@(posedge clk) disable iff (rst)
        (both_low && vref_rd_next) ##1 (both_low && veng_wen_n) |-> veng_rd_next);

    assert_single_flag_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({veng_rd_next, vref_rd_next}));

    assert_eng_flag_read_R5: assert property (@(posedge clk) disable iff (rst)
        veng_rd_next |-> (!veng_cen_n && veng_wen_n));

    assert_refresh_ro_R6: assert property (@(posedge clk) disable iff (rst)
        vref_rd_next |-> (vmem_wen_n && vmem_wdata == '0));

    assert_pal_refresh_ro_R6: assert property (@(posedge clk) disable iff (rst)
        lref_rd_next |-> (lmem_wen_n && lmem_wdata == '0));

    assert_pal_prio_R7: assert property (@(posedge clk) disable iff (rst)
        !lsw_cen_n |-> !lref_rd_next);

    assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (vsw_cen_n && veng_cen_n && vref_cen_n) |-> (vmem_cen_n && vmem_wen_n));

    assert_pal_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (lsw_cen_n && lref_cen_n) |-> (lmem_cen_n && lmem_wen_n));

endmodule

bind shared_vmem_arbiter vmem_arb_checker #(.VADDR_W(VADDR_W), .DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .vsw_addr     (vsw_addr),
    .vsw_cen_n    (vsw_cen_n),
    .veng_cen_n   (veng_cen_n),
    .veng_wen_n   (veng_wen_n),
    .veng_rd_next (veng_rd_next),
    .vref_cen_n   (vref_cen_n),
    .vref_rd_next (vref_rd_next),
    .vmem_addr    (vmem_addr),
    .vmem_wdata   (vmem_wdata),
    .vmem_wen_n   (vmem_wen_n),
    .vmem_cen_n   (vmem_cen_n),
    .lsw_cen_n    (lsw_cen_n),
    .lref_cen_n   (lref_cen_n),
    .lref_rd_next (lref_rd_next),
    .lmem_wdata   (lmem_wdata),
    .lmem_wen_n   (lmem_wen_n),
    .lmem_cen_n   (lmem_cen_n)
);

// File: tb/sim_shared_vmem_arbiter.sv
module sim_shared_vmem_arbiter;

    localparam int VA = 14;
    localparam int LA = 8;
    localparam int DW = 16;

    localparam logic [VA-1:0] SW_A  = 14'h0011;
    localparam logic [VA-1:0] ENG_A = 14'h0222;
    localparam logic [VA-1:0] REF_A = 14'h0333;
    localparam logic [DW-1:0] SW_D  = 16'hA001;
    localparam logic [DW-1:0] ENG_D = 16'hB002;
    localparam logic [LA-1:0] LSW_A = 8'h21;
    localparam logic [LA-1:0] LREF_A = 8'h7E;
    localparam logic [DW-1:0] LSW_D = 16'hC003;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [VA-1:0] vsw_addr = SW_A, veng_addr = ENG_A, vref_addr = REF_A, vmem_addr;
    logic [DW-1:0] vsw_wdata = SW_D, veng_wdata = ENG_D, vmem_wdata, vmem_rdata = '0;
    logic [DW-1:0] vsw_rdata, veng_rdata, vref_rdata;
    logic vsw_wen_n = 1'b1, vsw_cen_n = 1'b1, veng_wen_n = 1'b1, veng_cen_n = 1'b1;
    logic vref_cen_n = 1'b1, veng_rd_next, vref_rd_next, vmem_wen_n, vmem_cen_n;
    logic [LA-1:0] lsw_addr = LSW_A, lref_addr = LREF_A, lmem_addr;
    logic [DW-1:0] lsw_wdata = LSW_D, lmem_wdata, lmem_rdata = '0, lsw_rdata, lref_rdata;
    logic lsw_wen_n = 1'b1, lsw_cen_n = 1'b1, lref_cen_n = 1'b1;
    logic lref_rd_next, lmem_wen_n, lmem_cen_n;

    shared_vmem_arbiter #(.VADDR_W(VA), .LADDR_W(LA), .DW(DW)) u0 (
        .clk(clk), .rst(rst),
        .vsw_addr(vsw_addr), .vsw_wdata(vsw_wdata), .vsw_wen_n(vsw_wen_n),
        .vsw_cen_n(vsw_cen_n), .vsw_rdata(vsw_rdata),
        .veng_addr(veng_addr), .veng_wdata(veng_wdata), .veng_wen_n(veng_wen_n),
        .veng_cen_n(veng_cen_n), .veng_rdata(veng_rdata), .veng_rd_next(veng_rd_next),
        .vref_addr(vref_addr), .vref_cen_n(vref_cen_n), .vref_rdata(vref_rdata),
        .vref_rd_next(vref_rd_next),
        .vmem_addr(vmem_addr), .vmem_wdata(vmem_wdata), .vmem_wen_n(vmem_wen_n),
        .vmem_cen_n(vmem_cen_n), .vmem_rdata(vmem_rdata),
        .lsw_addr(lsw_addr), .lsw_wdata(lsw_wdata), .lsw_wen_n(lsw_wen_n),
        .lsw_cen_n(lsw_cen_n), .lsw_rdata(lsw_rdata),
        .lref_addr(lref_addr), .lref_cen_n(lref_cen_n), .lref_rdata(lref_rdata),
        .lref_rd_next(lref_rd_next),
        .lmem_addr(lmem_addr), .lmem_wdata(lmem_wdata), .lmem_wen_n(lmem_wen_n),
        .lmem_cen_n(lmem_cen_n), .lmem_rdata(lmem_rdata)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit fav_ref = 1'b1;  // reference pointer: 1 = refresh wins ties

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One frame-memory cycle: drive on the falling edge, check before the rising edge
    task automatic vstep(bit s_c, bit s_w, bit e_c, bit e_w, bit r_c, string req);
        int sel;
        @(negedge clk);
        vsw_cen_n  = ~s_c;
        vsw_wen_n  = ~s_w;
        veng_cen_n = ~e_c;
        veng_wen_n = ~e_w;
        vref_cen_n = ~r_c;
        #2;
        if (s_c)             sel = 1;
        else if (e_c && r_c) sel = fav_ref ? 3 : 2;
        else if (e_c)        sel = 2;
        else if (r_c)        sel = 3;
        else                 sel = 0;
        case (sel)
            0: begin
                chk(req, "idle cen_n", 32'(vmem_cen_n), 32'd1);
                chk(req, "idle wen_n", 32'(vmem_wen_n), 32'd1);
            end
            1: begin
                chk(req, "sw addr", 32'(vmem_addr), 32'(SW_A));
                chk(req, "sw wdata", 32'(vmem_wdata), 32'(SW_D));
                chk(req, "sw wen_n", 32'(vmem_wen_n), 32'(!s_w));
                chk(req, "sw cen_n", 32'(vmem_cen_n), 32'd0);
            end
            2: begin
                chk(req, "eng addr", 32'(vmem_addr), 32'(ENG_A));
                chk(req, "eng wdata", 32'(vmem_wdata), 32'(ENG_D));
                chk(req, "eng wen_n", 32'(vmem_wen_n), 32'(!e_w));
                chk(req, "eng cen_n", 32'(vmem_cen_n), 32'd0);
            end
            default: begin
                chk(req, "ref addr", 32'(vmem_addr), 32'(REF_A));
                chk(req, "ref wdata zero R6", 32'(vmem_wdata), 32'd0);
                chk(req, "ref wen_n high R6", 32'(vmem_wen_n), 32'd1);
                chk(req, "ref cen_n", 32'(vmem_cen_n), 32'd0);
            end
        endcase
        chk(req, "eng rd_next R5", 32'(veng_rd_next), 32'(sel == 2 && !e_w));
        chk(req, "ref rd_next R5", 32'(vref_rd_next), 32'(sel == 3));
        if (sel == 2) fav_ref = 1'b1;
        if (sel == 3) fav_ref = 1'b0;
    endtask

    task automatic lstep(bit s_c, bit s_w, bit r_c, string req);
        @(negedge clk);
        lsw_cen_n  = ~s_c;
        lsw_wen_n  = ~s_w;
        lref_cen_n = ~r_c;
        #2;
        if (s_c) begin
            chk(req, "pal sw addr", 32'(lmem_addr), 32'(LSW_A));
            chk(req, "pal sw wdata", 32'(lmem_wdata), 32'(LSW_D));
            chk(req, "pal sw wen_n", 32'(lmem_wen_n), 32'(!s_w));
        end else if (r_c) begin
            chk(req, "pal ref addr", 32'(lmem_addr), 32'(LREF_A));
            chk(req, "pal ref wdata zero R6", 32'(lmem_wdata), 32'd0);
            chk(req, "pal ref wen_n high R6", 32'(lmem_wen_n), 32'd1);
        end else begin
            chk(req, "pal idle wen_n R8", 32'(lmem_wen_n), 32'd1);
        end
        chk(req, "pal cen_n", 32'(lmem_cen_n), 32'(!(s_c || r_c)));
        chk(req, "pal ref rd_next R7", 32'(lref_rd_next), 32'(!s_c && r_c));
    endtask

    task automatic t_reset();
        @(negedge clk);
        #2;
        chk("R8", "reset vmem cen_n", 32'(vmem_cen_n), 32'd1);
        chk("R8", "reset vmem wen_n", 32'(vmem_wen_n), 32'd1);
        chk("R8", "reset lmem cen_n", 32'(lmem_cen_n), 32'd1);
        chk("R8", "reset lmem wen_n", 32'(lmem_wen_n), 32'd1);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_sw_priority();
        vstep(1, 1, 1, 0, 1, "R1");   // software write beats both
        vstep(1, 0, 1, 1, 1, "R1");   // software read beats engine write
    endtask

    task automatic t_round_robin();
        vstep(0, 0, 1, 0, 1, "R2");   // refresh favoured from reset
        chk("R2", "first tie to refresh", 32'(vref_rd_next), 32'd1);
        vstep(0, 0, 1, 0, 1, "R3");
        vstep(0, 0, 1, 0, 1, "R3");
        vstep(1, 0, 1, 0, 1, "R3");   // software cycle: pointer holds
        vstep(0, 0, 0, 0, 0, "R3");   // idle cycle: pointer holds
        vstep(0, 0, 1, 0, 1, "R3");
        chk("R3", "engine after hold", 32'(veng_rd_next), 32'd1);
    endtask

    task automatic t_single();
        vstep(0, 0, 1, 0, 0, "R4");   // engine alone while refresh favoured
        chk("R4", "lone engine granted", 32'(veng_rd_next), 32'd1);
        vstep(0, 0, 0, 0, 1, "R4");   // refresh alone
        vstep(0, 0, 0, 0, 1, "R4");   // refresh alone although engine favoured
        chk("R4", "lone refresh granted", 32'(vref_rd_next), 32'd1);
        vstep(0, 0, 1, 0, 1, "R4");
    endtask

    task automatic t_eng_write();
        vstep(0, 0, 1, 1, 0, "R5");
        chk("R5", "engine write no flag", 32'(veng_rd_next), 32'd0);
        vstep(0, 0, 1, 1, 1, "R5");
        vstep(0, 0, 1, 1, 1, "R5");
        vstep(0, 0, 0, 0, 0, "R8");
    endtask

    task automatic t_palette();
        lstep(1, 1, 1, "R7");
        lstep(1, 0, 1, "R7");
        lstep(0, 0, 1, "R7");
        lstep(0, 0, 0, "R8");
    endtask

    task automatic t_rdata();
        @(negedge clk);
        vmem_rdata = 16'h5A5A;
        lmem_rdata = 16'h3C3C;
        #2;
        chk("R9", "vsw_rdata", 32'(vsw_rdata), 32'h5A5A);
        chk("R9", "veng_rdata", 32'(veng_rdata), 32'h5A5A);
        chk("R9", "vref_rdata", 32'(vref_rdata), 32'h5A5A);
        chk("R9", "lsw_rdata", 32'(lsw_rdata), 32'h3C3C);
        chk("R9", "lref_rdata", 32'(lref_rdata), 32'h3C3C);
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_sw_priority();
        t_round_robin();
        t_single();
        t_eng_write();
        t_palette();
        t_rdata();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule